// File: doc/BRIEF.md
# Multiphase Fractional Feedback Divider Control

This block is the digital half of a fractional feedback divider for a frequency synthesizer whose oscillator supplies several equally spaced clock phases. An integer counter counts oscillator cycles on the reference phase. A phase pointer chooses which oscillator phase closes each output period. When phase mixing is enabled, the pointer also has half-step positions, which a mixer of two neighbouring phases produces. Each output period, the pointer moves earlier by a fractional step taken from the ratio input. Whenever the pointer wraps past phase zero, the integer count for that period is made one cycle shorter, so the long-run ratio matches the request exactly.

In the default configuration there are ten oscillator phases with mixing, which gives twenty positions per oscillator cycle. The base ratio is sixty. A step of six moves the pointer back three phases each period, and a step of five gives a period of 59.75 oscillator cycles. The spread-spectrum profile logic drives the step and an enable. The block returns a phase-select code, a mix-enable and a one-cycle divided-clock pulse. All of these are modelled in the reference-phase clock domain.

Top module: `mphase_frac_div`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `div_clk`, `phase_sel` and `mix_en` are all 0.
- R2: With `div_en` low, the pulses on `div_clk` are exactly BASE_DIV (60) clock cycles apart, and `phase_sel`/`mix_en` keep their current values whatever `frac_step` holds.
- R3: With `div_en` high and step f, consecutive output edges are BASE_DIV*2*NPH − f position units apart. An edge's position is the pulse's cycle number × 2*NPH plus the index `phase_sel`*2 + `mix_en`, and one unit is 1/(2*NPH) of a clock cycle.
- R4: From one pulse to the next, the index moves from a to (a − f) mod 2*NPH. The cycle gap between the two pulses is BASE_DIV−1 when f > a (a wrap) and BASE_DIV otherwise.
- R5: `div_clk` is high for exactly one clock cycle in each output period.
- R6: `phase_sel` and `mix_en` change only in the cycle right after a `div_clk` pulse, with `div_clk` low in that cycle.
- R7: A `frac_step` value above 2*NPH−1 (19) is treated as 2*NPH−1.
- R8: With `div_en` high and a step of 0, the index never moves and the period is BASE_DIV cycles. For every step, the average period over many periods equals the requested ratio exactly.
- R9: `phase_sel` is always below NPH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator phase clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_en | input | 1 | Fractional stepping enable from the profile logic |
| frac_step | input | $clog2(2*NPH) | Pointer step per period, in 1/(2*NPH) cycle units |
| phase_sel | output | $clog2(NPH) | Oscillator phase multiplexer select |
| mix_en | output | 1 | Selects the half-step between `phase_sel` and the next phase |
| div_clk | output | 1 | Divided clock pulse, one cycle per output period |

## Verification
The checker assumes that the profile logic holds reset long enough for the registers to settle. It also relies on BASE_DIV being at least three, so that a shortened period still leaves a low cycle between pulses in which the select can move. A step or enable that changes in mid-period is taken only at the next terminal count. The bench therefore changes inputs at arbitrary points and then lets two pulses pass before it compares index movement, gaps and edge spacing with the values it computes for itself.

// File: rtl/mpfd_pkg.sv
package mpfd_pkg;

   // number of pointer positions per oscillator cycle
   function automatic int unsigned pos_count(input int unsigned nph, input bit mix);
      return mix ? 2 * nph : nph;
   endfunction

   // bits needed to hold a value in [0, n-1], never below one
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/mpfd_step_sat.sv
module mpfd_step_sat #(
   parameter int unsigned FW  = 5,
   parameter int unsigned POS = 20,
   parameter int unsigned AW  = 5
) (
   input  logic          en_i,
   input  logic [FW-1:0] raw_i,
   output logic [AW-1:0] step_o
);
   localparam int unsigned MAXSTEP = POS - 1;

   always_comb begin
      if (!en_i)
         step_o = '0;
      else if (32'(raw_i) > MAXSTEP)
         step_o = AW'(MAXSTEP);
      else
         step_o = AW'(raw_i);
   end
endmodule

// File: rtl/mpfd_phase_acc.sv
module mpfd_phase_acc #(
   parameter int unsigned POS = 20,
   parameter int unsigned AW  = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv_i,
   input  logic [AW-1:0] step_i,
   output logic [AW-1:0] acc_o,
   output logic          wrap_o
);
   logic [AW-1:0] acc_q;
   logic [AW:0]   diff;
   logic [AW:0]   wrapped;

   always_comb begin
      diff    = {1'b0, acc_q} - {1'b0, step_i};
      wrapped = diff + (AW+1)'(POS);
      wrap_o  = diff[AW];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         acc_q <= '0;
      else if (adv_i)
         acc_q <= wrap_o ? wrapped[AW-1:0] : diff[AW-1:0];
   end

   assign acc_o = acc_q;
endmodule

// File: rtl/mpfd_int_cnt.sv
module mpfd_int_cnt #(
   parameter int unsigned BASE_DIV = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic short_i,
   output logic adv_o,
   output logic pulse_o
);
   localparam int unsigned CW = $clog2(BASE_DIV + 1);

   logic [CW-1:0] cnt_q;
   logic          pulse_q;

   assign adv_o = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= CW'(BASE_DIV - 1);
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= adv_o;
         if (adv_o)
            cnt_q <= CW'(BASE_DIV - 1) - CW'(short_i);
         else
            cnt_q <= cnt_q - 1'b1;
      end
   end

   assign pulse_o = pulse_q;
endmodule

// File: rtl/mpfd_sel_map.sv
module mpfd_sel_map #(
   parameter int unsigned AW  = 5,
   parameter int unsigned SW  = 4,
   parameter bit          MIX = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] acc_i,
   output logic [SW-1:0] sel_o,
   output logic          mix_o
);
   logic [SW-1:0] sel_q;
   logic          mix_q;

   generate
      if (MIX) begin : g_mix
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sel_q <= '0;
               mix_q <= 1'b0;
            end else if (load_i) begin
               sel_q <= SW'(acc_i >> 1);
               mix_q <= acc_i[0];
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n)
               sel_q <= '0;
            else if (load_i)
               sel_q <= SW'(acc_i);
         end
         assign mix_q = 1'b0;
      end
   endgenerate

   assign sel_o = sel_q;
   assign mix_o = mix_q;
endmodule

// File: rtl/mphase_frac_div.sv
module mphase_frac_div #(
   parameter int unsigned NPH      = 10,
   parameter int unsigned BASE_DIV = 60,
   parameter bit          MIX      = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        div_en,
   input  logic [$clog2(2*NPH)-1:0]    frac_step,
   output logic [$clog2(NPH)-1:0]      phase_sel,
   output logic                        mix_en,
   output logic                        div_clk
);
   import mpfd_pkg::*;

   localparam int unsigned FW  = $clog2(2*NPH);
   localparam int unsigned SW  = $clog2(NPH);
   localparam int unsigned POS = pos_count(NPH, MIX);
   localparam int unsigned AW  = idx_bits(POS);

   generate
      if (NPH < 2) begin : g_bad_nph
         $error("mphase_frac_div: NPH must be at least 2");
      end
      if (BASE_DIV < 3) begin : g_bad_base
         $error("mphase_frac_div: BASE_DIV must be at least 3");
      end
   endgenerate

   logic [AW-1:0] step;
   logic [AW-1:0] acc;
   logic          wrap;
   logic          adv;
   logic          pulse;

   mpfd_step_sat #(.FW(FW), .POS(POS), .AW(AW)) u_sat (
      .en_i   (div_en),
      .raw_i  (frac_step),
      .step_o (step)
   );

   mpfd_phase_acc #(.POS(POS), .AW(AW)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv_i  (adv),
      .step_i (step),
      .acc_o  (acc),
      .wrap_o (wrap)
   );

   mpfd_int_cnt #(.BASE_DIV(BASE_DIV)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .short_i (wrap),
      .adv_o   (adv),
      .pulse_o (pulse)
   );

   mpfd_sel_map #(.AW(AW), .SW(SW), .MIX(MIX)) u_map (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (pulse),
      .acc_i  (acc),
      .sel_o  (phase_sel),
      .mix_o  (mix_en)
   );

   assign div_clk = pulse;
endmodule

// File: rtl/mphase_frac_div_chk.sv
module mphase_frac_div_chk #(
   parameter int unsigned NPH      = 10,
   parameter int unsigned BASE_DIV = 60
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [$clog2(NPH)-1:0] phase_sel,
   input logic                   mix_en,
   input logic                   div_clk
);
   int  gap_q;
   bit  seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q  <= 0;
         seen_q <= 1'b0;
      end else if (div_clk) begin
         gap_q  <= 0;
         seen_q <= 1'b1;
      end else begin
         gap_q <= gap_q + 1;
      end
   end

   // R5: one-cycle pulse
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      div_clk |=> !div_clk);

   // R6: select moves only just after a pulse
   a_r6_quiet_change: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(phase_sel) || !$stable(mix_en)) |-> ($past(div_clk) && !div_clk));

   // R9: select range
   a_r9_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
      32'(phase_sel) < NPH);

   // R4: period is the base count or one short
   a_r4_gap_len: assert property (@(posedge clk) disable iff (!rst_n)
      (div_clk && seen_q) |-> (gap_q == BASE_DIV - 1 || gap_q == BASE_DIV - 2));

   // R1: outputs idle right after reset
   a_r1_reset_idle: assert property (@(posedge clk)
      $rose(rst_n) |-> (!div_clk && phase_sel == '0 && !mix_en));
endmodule

bind mphase_frac_div mphase_frac_div_chk #(.NPH(NPH), .BASE_DIV(BASE_DIV)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .phase_sel (phase_sel),
   .mix_en    (mix_en),
   .div_clk   (div_clk)
);

// File: tb/mphase_frac_div_bench.sv
module mphase_frac_div_bench;
   localparam int NPH  = 10;
   localparam int BASE = 60;
   localparam int POS  = 2 * NPH;
   localparam int FW   = $clog2(2*NPH);
   localparam int SW   = $clog2(NPH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          div_en = 1'b0;
   logic [FW-1:0] frac_step = '0;
   logic [SW-1:0] phase_sel;
   logic          mix_en;
   logic          div_clk;

   int nchk = 0;
   int nbad = 0;
   int cyc  = 0;
   bit done = 1'b0;

   int last_idx = 0;
   bit last_div = 1'b0;
   int glitch = 0;
   int range_bad = 0;
   int long_pulse = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   mphase_frac_div u_mphase_frac_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .div_en    (div_en),
      .frac_step (frac_step),
      .phase_sel (phase_sel),
      .mix_en    (mix_en),
      .div_clk   (div_clk)
   );

   function automatic int idx_now();
      return 32'(phase_sel) * 2 + 32'(mix_en);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   // one negedge sample with the glitch, range and pulse-width observations
   task automatic sample();
      @(negedge clk);
      if (idx_now() != last_idx && !(last_div && !div_clk)) glitch++;
      if (32'(phase_sel) >= NPH) range_bad++;
      if (div_clk && last_div) long_pulse++;
      last_idx = idx_now();
      last_div = div_clk;
   endtask

   task automatic wait_pulse();
      sample();
      while (!div_clk) sample();
   endtask

   task automatic run_case(input int fr, input bit en, input int nper, input string req);
      int f, a, b, ca, cb, e0, c0;
      f = en ? ((fr > POS - 1) ? POS - 1 : fr) : 0;
      @(negedge clk);
      frac_step = FW'(fr);
      div_en = en;
      wait_pulse();
      wait_pulse();
      wait_pulse();
      a = idx_now(); ca = cyc;
      e0 = a; c0 = ca;
      for (int k = 0; k < nper; k++) begin
         wait_pulse();
         b = idx_now(); cb = cyc;
         chk(b == (a - f + POS) % POS, {req, " index step"}, b, (a - f + POS) % POS);
         chk(cb - ca == BASE - ((f > a) ? 1 : 0), {req, " R4 gap"}, cb - ca,
             BASE - ((f > a) ? 1 : 0));
         chk((cb * POS + b) - (ca * POS + a) == BASE * POS - f, {req, " R3 edge spacing"},
             (cb * POS + b) - (ca * POS + a), BASE * POS - f);
         a = b; ca = cb;
      end
      chk((ca * POS + a) - (c0 * POS + e0) == nper * (BASE * POS - f), {req, " R8 average"},
          (ca * POS + a) - (c0 * POS + e0), nper * (BASE * POS - f));
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(!div_clk && phase_sel == '0 && !mix_en, "R1 in reset",
          {28'd0, div_clk, mix_en, 2'(phase_sel)}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!div_clk && phase_sel == '0 && !mix_en, "R1 after reset",
          {28'd0, div_clk, mix_en, 2'(phase_sel)}, 0);
   endtask

   task automatic t_hold(input string req);
      int idx0;
      run_case(13, 1'b0, 6, req);
      idx0 = idx_now();
      for (int k = 0; k < 2 * BASE; k++) sample();
      chk(idx_now() == idx0, {req, " select held"}, idx_now(), idx0);
   endtask

   task automatic t_glitch_summary();
      chk(glitch == 0, "R6 select change outside post-pulse cycle", glitch, 0);
      chk(range_bad == 0, "R9 phase_sel range", range_bad, 0);
      chk(long_pulse == 0, "R5 pulse width", long_pulse, 0);
   endtask

   initial begin
      t_reset();
      t_hold("R2 from reset");
      run_case(6, 1'b1, 25, "R3 three-phase step");
      run_case(5, 1'b1, 25, "R3 quarter-cycle step");
      run_case(1, 1'b1, 45, "R4 half-phase wrap");
      run_case(19, 1'b1, 25, "R4 max step");
      run_case(31, 1'b1, 25, "R7 saturated step");
      run_case(0, 1'b1, 10, "R8 zero step");
      run_case(7, 1'b1, 5, "R3 pre-hold");
      t_hold("R2 after stepping");
      t_glitch_summary();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

   always @(posedge clk) begin
      if (!done && cyc > 150000) begin
         done = 1'b1;
         nchk++;
         nbad++;
         $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
         $display("test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end
endmodule